// File: doc/BRIEF.md
# Four-Channel Serial Controller Register Front End

This block is the software-visible register file of a four-channel serial DMA controller. A processor reaches it through a plain 32-bit read/write register bus with a 14-bit byte address. Each channel has a private 256-byte window holding its transmit and receive ring bound registers. A global mask turns the transmit and receive sides of each channel on or off. A command register switches whole channels on or off, and the opcodes it accepts depend on a chip-mode input.

The ring engines, which are outside this block, read the exported ring bounds, enables and channel state. A one-cycle load strobe tells an engine to reload its current descriptor pointer from a newly written start value. The engines return single-cycle completion pulses for transmit and receive. These pulses set sticky pending flags. The flags are gated by the enables and gathered into an interrupt summary word, and the OR of that word drives the interrupt line. Software acknowledges the interrupt by writing the summary address.

Top module: `ser_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, every stored register is zero, all channels are inactive, `irq` is low, all strobes are low and `bus_rdata` is zero.
- R2: Channel c (0..3) decodes at byte addresses (c+1)*0x100 plus an offset. Offset 0x80 is the TX ring start, 0x84 the TX ring end, 0x88 the RX ring start and 0x8C the RX ring end. Each is a 32-bit read/write register and appears on the ring output buses at bit slice [32c+31:32c].
- R3: A write to a TX or RX start register raises bit c of `tx_ptr_load` or `rx_ptr_load` for exactly one cycle. That is the first cycle in which the new start value shows on the outputs.
- R4: Address 0x14 is the enable mask. Only bits [7:0] are stored, and the upper bits read zero. Bit 2c is the TX enable of channel c and bit 2c+1 is its RX enable.
- R5: A write to 0x2C24 is a command. Bits [19:12] are the opcode and bits [1:0] select the channel. With `chip_mode`=0, opcode 0x00 activates the channel and 0x10 deactivates it.
- R6: With `chip_mode`=1, opcode 0x00 activates the channel and either 0x30 or 0x50 deactivates it. Any other opcode in either mode leaves every channel's state unchanged.
- R7: A `tx_evt`/`rx_evt` pulse on channel c sets a sticky pending flag. A read of 0x0 returns bit c = TX pending AND TX enable, and bit 4+c = RX pending AND RX enable, with all other bits zero.
- R8: Any write to 0x0 clears every pending flag. An event pulse in the same cycle as that write survives the clear.
- R9: `irq` is high exactly when the summary word at 0x0 is nonzero.
- R10: 0x2C2C always reads 0x0000FFFF. 0x2C00 is a 32-bit read/write options register. Unmapped addresses read zero, and writes to them change nothing. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_mode | input | 1 | Selects the command opcode set |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_evt | input | 4 | Per-channel TX completion pulse |
| rx_evt | input | 4 | Per-channel RX completion pulse |
| ch_active | output | 4 | Per-channel on/off state set by commands |
| ch_tx_en | output | 4 | Per-channel TX enable from the mask |
| ch_rx_en | output | 4 | Per-channel RX enable from the mask |
| tx_ring_start | output | 128 | TX ring start per channel |
| tx_ring_end | output | 128 | TX ring end per channel |
| rx_ring_start | output | 128 | RX ring start per channel |
| rx_ring_end | output | 128 | RX ring end per channel |
| tx_ptr_load | output | 4 | One-cycle TX current-pointer reload |
| rx_ptr_load | output | 4 | One-cycle RX current-pointer reload |
| irq | output | 1 | Interrupt, OR of the summary word |

## Verification
A corrupted pending flag or enable bit shows up on `irq` in the cycle after the edge that stored it. It also shows in the summary word one cycle after the read strobe. A wrong channel or field decode lands a value on the wrong slice of the ring buses, or on the wrong load-strobe bit, in the first cycle after the write. A command decode error leaves `ch_active` wrong immediately after the command write, and that state persists until the next command. A lost event during a clear appears as a zero summary where the bench expects the surviving bit.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 14;
    localparam int PAGE_LSB    = 8;
    localparam int PAGE_W      = ADDR_W - PAGE_LSB;
    localparam int OP_LSB      = 12;
    localparam int OP_W        = 8;

    localparam logic [ADDR_W-1:0] ADDR_IRQ  = 14'h0000;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 14'h0014;
    localparam logic [ADDR_W-1:0] ADDR_OPT  = 14'h2C00;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 14'h2C24;
    localparam logic [ADDR_W-1:0] ADDR_RESP = 14'h2C2C;

    localparam logic [PAGE_LSB-1:0] OFF_TX_START = 8'h80;
    localparam logic [PAGE_LSB-1:0] OFF_TX_END   = 8'h84;
    localparam logic [PAGE_LSB-1:0] OFF_RX_START = 8'h88;
    localparam logic [PAGE_LSB-1:0] OFF_RX_END   = 8'h8C;

    localparam logic [DATA_W-1:0] RESP_WORD = 32'h0000_FFFF;

    localparam logic [OP_W-1:0] OP_ON      = 8'h00;
    localparam logic [OP_W-1:0] OP_OFF_M0  = 8'h10;
    localparam logic [OP_W-1:0] OP_OFF_M1A = 8'h30;
    localparam logic [OP_W-1:0] OP_OFF_M1B = 8'h50;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ON,
        ACT_OFF
    } cmd_act_e;

    typedef enum logic [2:0] {
        RF_NONE,
        RF_TX_START,
        RF_TX_END,
        RF_RX_START,
        RF_RX_END
    } ring_field_e;

    typedef struct packed {
        logic [DATA_W-1:0] tx_start;
        logic [DATA_W-1:0] tx_end;
        logic [DATA_W-1:0] rx_start;
        logic [DATA_W-1:0] rx_end;
    } ring_regs_t;

    // Map an opcode to an action under the selected opcode set.
    function automatic cmd_act_e decode_cmd(input logic mode,
                                            input logic [OP_W-1:0] op);
        cmd_act_e act;
        act = ACT_NONE;
        if (op == OP_ON) begin
            act = ACT_ON;
        end else if (!mode && op == OP_OFF_M0) begin
            act = ACT_OFF;
        end else if (mode && (op == OP_OFF_M1A || op == OP_OFF_M1B)) begin
            act = ACT_OFF;
        end
        return act;
    endfunction

    function automatic ring_field_e decode_field(input logic [PAGE_LSB-1:0] offs);
        ring_field_e f;
        case (offs)
            OFF_TX_START: f = RF_TX_START;
            OFF_TX_END:   f = RF_TX_END;
            OFF_RX_START: f = RF_RX_START;
            OFF_RX_END:   f = RF_RX_END;
            default:      f = RF_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ser_ring_regs.sv
module ser_ring_regs
    import ser_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                wr,
    input  logic [PAGE_LSB-1:0] offs,
    input  logic [DATA_W-1:0]   wdata,
    output ring_regs_t          ring,
    output logic                tx_load,
    output logic                rx_load,
    output logic [DATA_W-1:0]   rd_val
);

    ring_field_e field;

    always_comb begin
        field = decode_field(offs);
    end

    always_comb begin
        rd_val = '0;
        if (sel) begin
            case (field)
                RF_TX_START: rd_val = ring.tx_start;
                RF_TX_END:   rd_val = ring.tx_end;
                RF_RX_START: rd_val = ring.rx_start;
                RF_RX_END:   rd_val = ring.rx_end;
                default:     rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring    <= '0;
            tx_load <= 1'b0;
            rx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            rx_load <= 1'b0;
            if (sel && wr) begin
                case (field)
                    RF_TX_START: begin
                        ring.tx_start <= wdata;
                        tx_load       <= 1'b1;
                    end
                    RF_TX_END:   ring.tx_end <= wdata;
                    RF_RX_START: begin
                        ring.rx_start <= wdata;
                        rx_load       <= 1'b1;
                    end
                    RF_RX_END:   ring.rx_end <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // R3: a start write strobes a reload aligned with the new value
    a_r3_tx_load: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && offs == OFF_TX_START) |=> (tx_load && ring.tx_start == $past(wdata)));

    a_r3_rx_load: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && offs == OFF_RX_START) |=> (rx_load && ring.rx_start == $past(wdata)));

    a_r2_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr) |=> $stable(ring));

endmodule

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
    import ser_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_mode,
    input  logic              cmd_we,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [CH_W-1:0]   cmd_ch,
    output logic [NUM_CH-1:0] ch_active
);

    cmd_act_e act;

    always_comb begin
        act = decode_cmd(chip_mode, cmd_op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_active <= '0;
        end else if (cmd_we && (int'(cmd_ch) < NUM_CH)) begin
            case (act)
                ACT_ON:  ch_active[cmd_ch] <= 1'b1;
                ACT_OFF: ch_active[cmd_ch] <= 1'b0;
                default: ;
            endcase
        end
    end

    // R5: opcode 0x00 turns the addressed channel on in both modes
    a_r5_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_op == OP_ON && int'(cmd_ch) < NUM_CH) |=> ch_active[$past(cmd_ch)]);

    // R6: unknown opcodes leave every channel untouched
    a_r6_ignore: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_op != OP_ON && cmd_op != OP_OFF_M0 &&
         cmd_op != OP_OFF_M1A && cmd_op != OP_OFF_M1B) |=> $stable(ch_active));

    a_r6_mode1_off: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && chip_mode && (cmd_op == OP_OFF_M1A || cmd_op == OP_OFF_M1B) &&
         int'(cmd_ch) < NUM_CH) |=> !ch_active[$past(cmd_ch)]);

endmodule

// File: rtl/ser_irq_summary.sv
module ser_irq_summary
    import ser_regs_pkg::*;
#(
    parameter int NUM_CH  = 4,
    localparam int RX_LANE = NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] rx_evt,
    input  logic              clr,
    input  logic [NUM_CH-1:0] tx_en,
    input  logic [NUM_CH-1:0] rx_en,
    output logic [DATA_W-1:0] summary,
    output logic              irq
);

    logic [NUM_CH-1:0] pend_tx;
    logic [NUM_CH-1:0] pend_rx;

    // A clear drops old flags but keeps any event of the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_tx <= '0;
            pend_rx <= '0;
        end else if (clr) begin
            pend_tx <= tx_evt;
            pend_rx <= rx_evt;
        end else begin
            pend_tx <= pend_tx | tx_evt;
            pend_rx <= pend_rx | rx_evt;
        end
    end

    always_comb begin
        summary = '0;
        summary[NUM_CH-1:0]              = pend_tx & tx_en;
        summary[RX_LANE +: NUM_CH]       = pend_rx & rx_en;
        irq = |summary;
    end

    // R8: an event in the clear cycle survives
    a_r8_evt_survives: assert property (@(posedge clk) disable iff (rst)
        (tx_evt != '0 || rx_evt != '0) |=>
        (((pend_tx & $past(tx_evt)) == $past(tx_evt)) &&
         ((pend_rx & $past(rx_evt)) == $past(rx_evt))));

    // R8: a clear with no events empties every flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && tx_evt == '0 && rx_evt == '0) |=> (pend_tx == '0 && pend_rx == '0));

    // R7: flags are sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (((pend_tx & $past(pend_tx)) == $past(pend_tx)) &&
                  ((pend_rx & $past(pend_rx)) == $past(pend_rx))));

endmodule

// File: rtl/ser_ctrl_regs.sv
module ser_ctrl_regs
    import ser_regs_pkg::*;
#(
    parameter int NUM_CH   = 4,
    localparam int MASK_W  = 2 * NUM_CH,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BUS_W   = NUM_CH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_mode,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] rx_evt,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] ch_tx_en,
    output logic [NUM_CH-1:0] ch_rx_en,
    output logic [BUS_W-1:0]  tx_ring_start,
    output logic [BUS_W-1:0]  tx_ring_end,
    output logic [BUS_W-1:0]  rx_ring_start,
    output logic [BUS_W-1:0]  rx_ring_end,
    output logic [NUM_CH-1:0] tx_ptr_load,
    output logic [NUM_CH-1:0] rx_ptr_load,
    output logic              irq
);

    logic [MASK_W-1:0] en_mask;
    logic [DATA_W-1:0] opt_reg;
    logic [DATA_W-1:0] summary;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] ch_rd_any;
    logic [DATA_W-1:0] rd_mux;
    logic              clr_we;
    logic              cmd_we;
    ring_regs_t        ring [NUM_CH];

    assign clr_we = bus_wr && bus_addr == ADDR_IRQ;
    assign cmd_we = bus_wr && bus_addr == ADDR_CMD;

    // Per-channel ring windows
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_addr[ADDR_W-1:PAGE_LSB] == PAGE_W'(c + 1);

        ser_ring_regs u_ring (
            .clk     (clk),
            .rst     (rst),
            .sel     (hit),
            .wr      (bus_wr),
            .offs    (bus_addr[PAGE_LSB-1:0]),
            .wdata   (bus_wdata),
            .ring    (ring[c]),
            .tx_load (tx_ptr_load[c]),
            .rx_load (rx_ptr_load[c]),
            .rd_val  (ch_rd[c])
        );

        assign tx_ring_start[c*DATA_W +: DATA_W] = ring[c].tx_start;
        assign tx_ring_end  [c*DATA_W +: DATA_W] = ring[c].tx_end;
        assign rx_ring_start[c*DATA_W +: DATA_W] = ring[c].rx_start;
        assign rx_ring_end  [c*DATA_W +: DATA_W] = ring[c].rx_end;
        assign ch_tx_en[c] = en_mask[2*c];
        assign ch_rx_en[c] = en_mask[2*c+1];
    end

    ser_cmd_decode #(.NUM_CH(NUM_CH)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .chip_mode (chip_mode),
        .cmd_we    (cmd_we),
        .cmd_op    (bus_wdata[OP_LSB +: OP_W]),
        .cmd_ch    (bus_wdata[CH_W-1:0]),
        .ch_active (ch_active)
    );

    ser_irq_summary #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .tx_evt  (tx_evt),
        .rx_evt  (rx_evt),
        .clr     (clr_we),
        .tx_en   (ch_tx_en),
        .rx_en   (ch_rx_en),
        .summary (summary),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask <= '0;
            opt_reg <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_MASK) en_mask <= bus_wdata[MASK_W-1:0];
            if (bus_addr == ADDR_OPT)  opt_reg <= bus_wdata;
        end
    end

    always_comb begin
        ch_rd_any = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ch_rd_any = ch_rd_any | ch_rd[c];
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_IRQ:  rd_mux = summary;
            ADDR_MASK: rd_mux = DATA_W'(en_mask);
            ADDR_OPT:  rd_mux = opt_reg;
            ADDR_RESP: rd_mux = RESP_WORD;
            default:   rd_mux = ch_rd_any;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R10: the response register always answers with the fixed word
    a_r10_resp: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_RESP) |=> bus_rdata == RESP_WORD);

    // R10: read data holds between reads
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R9: interrupt needs at least one enabled lane
    a_r9_irq_enabled: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ch_tx_en != '0 || ch_rx_en != '0));

endmodule

// File: tb/ser_ctrl_regs_test.sv
module ser_ctrl_regs_test;

    localparam int  NCH = 4;
    localparam time CYC = 5ns;

    logic              clk = 1'b0;
    logic              rst;
    logic              chip_mode;
    logic              bus_wr;
    logic              bus_rd;
    logic [13:0]       bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    tx_evt;
    logic [NCH-1:0]    rx_evt;
    logic [NCH-1:0]    ch_active;
    logic [NCH-1:0]    ch_tx_en;
    logic [NCH-1:0]    ch_rx_en;
    logic [NCH*32-1:0] tx_ring_start;
    logic [NCH*32-1:0] tx_ring_end;
    logic [NCH*32-1:0] rx_ring_start;
    logic [NCH*32-1:0] rx_ring_end;
    logic [NCH-1:0]    tx_ptr_load;
    logic [NCH-1:0]    rx_ptr_load;
    logic              irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CYC/2) clk = ~clk;

    ser_ctrl_regs uut (
        .clk(clk), .rst(rst), .chip_mode(chip_mode),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt),
        .ch_active(ch_active), .ch_tx_en(ch_tx_en), .ch_rx_en(ch_rx_en),
        .tx_ring_start(tx_ring_start), .tx_ring_end(tx_ring_end),
        .rx_ring_start(rx_ring_start), .rx_ring_end(rx_ring_end),
        .tx_ptr_load(tx_ptr_load), .rx_ptr_load(rx_ptr_load), .irq(irq)
    );

    // Write/readback vectors: address, write value, expected readback
    localparam int NV = 9;
    localparam logic [13:0] V_ADDR [NV] = '{14'h0180, 14'h0284, 14'h0388, 14'h048C,
                                            14'h2C00, 14'h0014, 14'h2C2C, 14'h0500, 14'h0190};
    localparam logic [31:0] V_DATA [NV] = '{32'h1000_0000, 32'h2222_0040, 32'h3333_0080,
                                            32'h4444_00C0, 32'hDEAD_BEEF, 32'hFFFF_FFFF,
                                            32'h0000_1234, 32'h0000_ABCD, 32'h0000_5555};
    localparam logic [31:0] V_EXP  [NV] = '{32'h1000_0000, 32'h2222_0040, 32'h3333_0080,
                                            32'h4444_00C0, 32'hDEAD_BEEF, 32'h0000_00FF,
                                            32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] r);
        @(negedge clk);
        tx_evt = t; rx_evt = r;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0;
    endtask

    task automatic cmd(input logic [31:0] w);
        wr(14'h2C24, w);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CYC * 50000);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; chip_mode = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; tx_evt = '0; rx_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 active", 32'(ch_active), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 enables", 32'({ch_tx_en, ch_rx_en}), 32'h0);
        check("R1 loads", 32'({tx_ptr_load, rx_ptr_load}), 32'h0);
        check("R1 rings", 32'(|{tx_ring_start, tx_ring_end, rx_ring_start, rx_ring_end}), 32'h0);
        rd(14'h0014, d);
        check("R1 mask", d, 32'h0);

        // Table walk: R2 rings, R4 mask, R10 options/resp/unmapped
        for (int i = 0; i < NV; i++) wr(V_ADDR[i], V_DATA[i]);
        for (int i = 0; i < NV; i++) begin
            rd(V_ADDR[i], d);
            check($sformatf("R2/R4/R10 vec%0d", i), d, V_EXP[i]);
        end
        check("R2 ch0 tx start bus", tx_ring_start[31:0], 32'h1000_0000);
        check("R2 ch1 tx end bus", tx_ring_end[63:32], 32'h2222_0040);
        check("R2 ch2 rx start bus", rx_ring_start[95:64], 32'h3333_0080);
        check("R2 ch3 rx end bus", rx_ring_end[127:96], 32'h4444_00C0);
        check("R2 other slices untouched", tx_ring_start[127:32], 96'h0);
        check("R4 enables", 32'({ch_tx_en, ch_rx_en}), 32'hFF);
        check("R10 unmapped no effect", 32'(ch_active), 32'h0);

        // R3: load strobes
        wr(14'h0280, 32'h0000_0A00);
        check("R3 tx load pulse", 32'(tx_ptr_load), 32'h2);
        check("R3 tx value aligned", tx_ring_start[63:32], 32'h0000_0A00);
        check("R3 rx load idle", 32'(rx_ptr_load), 32'h0);
        @(negedge clk);
        check("R3 tx load one cycle", 32'(tx_ptr_load), 32'h0);
        wr(14'h0488, 32'h0000_0B00);
        check("R3 rx load pulse", 32'(rx_ptr_load), 32'h8);
        wr(14'h0484, 32'h0000_0C00);
        check("R3 end write no load", 32'({tx_ptr_load, rx_ptr_load}), 32'h0);

        // R5: mode 0 commands
        chip_mode = 1'b0;
        cmd(32'h0000_0002);
        check("R5 mode0 on", 32'(ch_active), 32'h4);
        cmd(32'h0001_0002);
        check("R5 mode0 off", 32'(ch_active), 32'h0);
        cmd(32'h0000_0003);
        cmd(32'h0003_0003);
        check("R6 mode0 ignores 0x30", 32'(ch_active), 32'h8);

        // R6: mode 1 commands
        chip_mode = 1'b1;
        cmd(32'h0001_0003);
        check("R6 mode1 ignores 0x10", 32'(ch_active), 32'h8);
        cmd(32'h0003_0003);
        check("R6 mode1 off 0x30", 32'(ch_active), 32'h0);
        cmd(32'h0000_0000);
        check("R6 mode1 on", 32'(ch_active), 32'h1);
        cmd(32'h0005_0000);
        check("R6 mode1 off 0x50", 32'(ch_active), 32'h0);
        cmd(32'h0007_0001);
        check("R6 unknown opcode", 32'(ch_active), 32'h0);

        // R7/R9: summary and gating
        wr(14'h0014, 32'h03);
        pulse(4'b0001, 4'b0011);
        check("R9 irq set", 32'(irq), 32'h1);
        rd(14'h0000, d);
        check("R7 summary gated", d, 32'h11);
        wr(14'h0014, 32'h0F);
        rd(14'h0000, d);
        check("R7 summary rx ch1", d, 32'h31);
        wr(14'h0014, 32'h00);
        check("R9 irq gated off", 32'(irq), 32'h0);
        rd(14'h0000, d);
        check("R7 summary all gated", d, 32'h0);

        // R8: clear and clear-with-event
        wr(14'h0000, 32'h0);
        wr(14'h0014, 32'h0F);
        check("R8 cleared irq", 32'(irq), 32'h0);
        rd(14'h0000, d);
        check("R8 cleared summary", d, 32'h0);
        pulse(4'b0001, 4'b0010);
        rd(14'h0000, d);
        check("R7 summary before clear", d, 32'h21);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 14'h0000; bus_wdata = '0; tx_evt = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; tx_evt = '0;
        check("R8 event survives clear irq", 32'(irq), 32'h1);
        rd(14'h0000, d);
        check("R8 event survives clear", d, 32'h02);
        wr(14'h0000, 32'h0);
        check("R9 irq low after clear", 32'(irq), 32'h0);

        finish_run();
    end

endmodule